// File: doc/BRIEF.md
# Linear Burst Read Port Controller

This block is the device-side read control of a synchronous memory that answers with linear bursts. A host asserts chip enable and pulses an address-valid strobe. On that clock edge the controller captures the start address and counts out a programmable initial latency. It then walks a linear address counter one step per clock and presents one data word per beat. An active-low end-of-burst flag marks either the final beat or the one before it. The memory array is modelled as a combinational lookup, so every data word follows from its address.

Output enable only gates the drivers of the data bus and of the flag; the burst sequence keeps running behind them. A burst ends early in two ways: chip enable goes low, or a fresh address-valid pulse restarts the sequence from a new address. The reset input stops everything at once. It floats the outputs and returns the configuration register to its asynchronous default. In that mode the clock is ignored and the port shows the word for the address on its inputs combinationally.

The sequencer is a three-state machine. `ST_IDLE` is the state with no burst. `ST_WAIT` counts the initial latency. `ST_BEAT` steps through the beats. Its named transitions are as follows:
- **latch** (`ST_IDLE`, `ST_WAIT` or `ST_BEAT` to `ST_WAIT`) on an address-valid pulse while chip enable is high and the port is in burst mode.
- **arrive** (`ST_WAIT` to `ST_BEAT`) when the latency count is used up.
- **finish** (`ST_BEAT` to `ST_IDLE`) after the last beat.
- **abort** (any state to `ST_IDLE`) when chip enable is low or the port is in asynchronous mode.

Top module: `burst_read_port`

## Requirements
- R1: While `rst_n` is low, `data_oe` and `eob_oe` are low at once, even in the middle of a burst. After `rst_n` is released the configuration is the default: asynchronous mode, latency field 3, 4-beat length, flag on the last beat.
- R2: In asynchronous mode (`cfg_wdata[0]` written 0) the clock has no effect. `arr_addr` equals `addr_in`. `data_out` is the array word for that address, (zero-extended address × 0x00010001) XOR 0xC3A50F1E modulo 2^32. `data_oe` equals `chip_en & out_en`, and `eob_n` stays 1.
- R3: Writing `cfg_wdata` with `cfg_we` high loads bit 0 (burst mode), bits 3:1 (latency L), bit 4 (8 beats when 1, else 4) and bit 5 (early flag). In burst mode an address-valid pulse with `chip_en` high latches `addr_in` at an edge E0. `data_oe` stays low until edge E(L-1), after which the first beat is shown. Latency field values 0 and 1 act as 2.
- R4: After the first beat, `arr_addr` rises by exactly one per clock with no wrap at any boundary, and `data_out` is the array word for `arr_addr`. After 4 or 8 beats the state returns to idle, `data_oe` drops and `arr_addr` holds the last beat address.
- R5: While `eob_oe` is high, `eob_n` is 1 except for exactly one cycle per complete burst. That cycle is the last beat when the early bit is 0 and the second-to-last beat when it is 1.
- R6: With `out_en` low, `data_oe` and `eob_oe` are low, but `arr_addr` keeps advancing. When `out_en` returns mid-burst, the beat due in that cycle is shown.
- R7: With `chip_en` low, `data_oe` is low. The next edge returns the sequencer to idle and clears `arr_addr` to 0. The burst does not resume when `chip_en` comes back.
- R8: An address-valid pulse during a wait or a burst restarts the sequence: it latches the new address and counts the full latency again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| addr_vld | input | 1 | Address-valid strobe, active high |
| out_en | input | 1 | Output enable for data and flag, active high |
| addr_in | input | AW | Start address (burst) or read address (async) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 6 | Configuration value (see R3) |
| data_out | output | DW | Read data |
| data_oe | output | 1 | Drive enable for `data_out` |
| eob_n | output | 1 | End-of-burst flag, active low |
| eob_oe | output | 1 | Drive enable for `eob_n` |
| arr_addr | output | AW | Current array address |

## Verification
The scoreboard predicts every cycle of each burst. This catches a latency that is off by one (the first beat a cycle early or late) and a counter that wraps when a burst starts just below a 256-word boundary. Beats with output enable dropped check that the address keeps moving; a design that stalled on output enable would show an old word when the enable returns. The early and late flag settings are both run, together with a flag hidden under a disabled output, so a flag held two cycles or placed on the wrong beat shows up. Restarts mid-burst, chip-enable aborts and reset in the middle of a burst check that no stale beat leaks out and that the configuration falls back to asynchronous reads.

// File: rtl/brp_pkg.sv
`timescale 1ns/1ps
package brp_pkg;

    localparam int LAT_W   = 3;
    localparam int CFG_W   = 6;
    localparam int MIN_LAT = 2;
    localparam int RST_LAT = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BEAT
    } brp_state_e;

    typedef struct packed {
        logic             early;
        logic             len8;
        logic [LAT_W-1:0] lat;
        logic             sync;
    } brp_cfg_t;

endpackage

// File: rtl/brp_cfg_reg.sv
`timescale 1ns/1ps
module brp_cfg_reg
    import brp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic             sync_o,
    output logic             len8_o,
    output logic             early_o,
    output logic [LAT_W-1:0] lat_eff_o
);

    localparam logic [LAT_W-1:0] LAT_FLOOR = LAT_W'(MIN_LAT);
    localparam logic [LAT_W-1:0] LAT_DFLT  = LAT_W'(RST_LAT);

    brp_cfg_t cfg_q;

    // Reset puts the port back into asynchronous reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sync  <= 1'b0;
            cfg_q.lat   <= LAT_DFLT;
            cfg_q.len8  <= 1'b0;
            cfg_q.early <= 1'b0;
        end else if (we) begin
            cfg_q <= brp_cfg_t'(wdata);
        end
    end

    always_comb begin
        sync_o    = cfg_q.sync;
        len8_o    = cfg_q.len8;
        early_o   = cfg_q.early;
        lat_eff_o = (cfg_q.lat < LAT_FLOOR) ? LAT_FLOOR : cfg_q.lat;
    end

    AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (lat_eff_o >= LAT_FLOOR)); // R3

endmodule

// File: rtl/brp_array.sv
`timescale 1ns/1ps
module brp_array #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);

    localparam logic [DW-1:0] MULT = DW'(32'h0001_0001);
    localparam logic [DW-1:0] SALT = DW'(32'hC3A5_0F1E);

    logic [DW+AW-1:0] ext;

    always_comb begin
        ext  = {{DW{1'b0}}, addr};
        word = (ext[DW-1:0] * MULT) ^ SALT;
    end

endmodule

// File: rtl/brp_seq.sv
`timescale 1ns/1ps
module brp_seq
    import brp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             addr_vld,
    input  logic [AW-1:0]    addr_in,
    input  logic             sync,
    input  logic             len8,
    input  logic             early,
    input  logic [LAT_W-1:0] lat_eff,
    output logic [AW-1:0]    cur_addr,
    output logic             in_beat,
    output logic             eob_lo
);

    localparam int BEAT_W = $clog2(LONG_LEN);
    localparam logic [BEAT_W-1:0] SHORT_LAST = BEAT_W'(SHORT_LEN - 1);
    localparam logic [BEAT_W-1:0] LONG_LAST  = BEAT_W'(LONG_LEN - 1);

    brp_state_e        st_q, st_d;
    logic [LAT_W-1:0]  wcnt_q, wcnt_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [AW-1:0]     cur_q, cur_d;
    logic [BEAT_W-1:0] last_idx, eob_idx;
    logic              restart;

    always_comb begin
        last_idx = len8 ? LONG_LAST : SHORT_LAST;
        eob_idx  = early ? (last_idx - 1'b1) : last_idx;
        restart  = chip_en && addr_vld && sync;
    end

    // Next-state process
    always_comb begin
        st_d   = st_q;
        wcnt_d = wcnt_q;
        beat_d = beat_q;
        cur_d  = cur_q;
        if (!chip_en || !sync) begin
            st_d  = ST_IDLE;                      // abort
            cur_d = chip_en ? cur_q : '0;
        end else if (restart) begin
            st_d   = ST_WAIT;                     // latch
            wcnt_d = LAT_W'(1);
            cur_d  = addr_in;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_WAIT: begin
                    if (wcnt_q == (lat_eff - 1'b1)) begin
                        st_d   = ST_BEAT;         // arrive
                        beat_d = '0;
                    end else begin
                        wcnt_d = wcnt_q + 1'b1;
                    end
                end
                ST_BEAT: begin
                    if (beat_q == last_idx) begin
                        st_d = ST_IDLE;           // finish
                    end else begin
                        beat_d = beat_q + 1'b1;
                        cur_d  = cur_q + 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wcnt_q <= '0;
            beat_q <= '0;
            cur_q  <= '0;
        end else begin
            st_q   <= st_d;
            wcnt_q <= wcnt_d;
            beat_q <= beat_d;
            cur_q  <= cur_d;
        end
    end

    // Output process
    always_comb begin
        cur_addr = cur_q;
        in_beat  = (st_q == ST_BEAT);
        eob_lo   = (st_q == ST_BEAT) && (beat_q == eob_idx);
    end

    AST_ASYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (st_q == ST_IDLE)); // R2
    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && sync && chip_en && !addr_vld && wcnt_q == (lat_eff - 1'b1))
        |=> (st_q == ST_BEAT && beat_q == '0 && cur_q == $past(cur_q))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BEAT && beat_q != last_idx && sync && chip_en && !addr_vld)
        |=> (cur_q == $past(cur_q) + 1'b1)); // R4
    AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eob_lo |=> !eob_lo); // R5
    AST_CE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (st_q == ST_IDLE && cur_q == '0)); // R7
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q == ST_WAIT && cur_q == $past(addr_in))); // R8

endmodule

// File: rtl/burst_read_port.sv
`timescale 1ns/1ps
module burst_read_port
    import brp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             addr_vld,
    input  logic             out_en,
    input  logic [AW-1:0]    addr_in,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic             eob_n,
    output logic             eob_oe,
    output logic [AW-1:0]    arr_addr
);

    logic             sync, len8, early;
    logic [LAT_W-1:0] lat_eff;
    logic [AW-1:0]    cur_addr;
    logic             in_beat, eob_lo;

    brp_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .sync_o    (sync),
        .len8_o    (len8),
        .early_o   (early),
        .lat_eff_o (lat_eff)
    );

    brp_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_en  (chip_en),
        .addr_vld (addr_vld),
        .addr_in  (addr_in),
        .sync     (sync),
        .len8     (len8),
        .early    (early),
        .lat_eff  (lat_eff),
        .cur_addr (cur_addr),
        .in_beat  (in_beat),
        .eob_lo   (eob_lo)
    );

    always_comb begin
        arr_addr = sync ? cur_addr : addr_in;
        data_oe  = rst_n && chip_en && out_en && (!sync || in_beat);
        eob_oe   = rst_n && chip_en && out_en;
        eob_n    = !(sync && eob_lo);
    end

    brp_array #(.AW(AW), .DW(DW)) u_arr (
        .addr (arr_addr),
        .word (data_out)
    );

    always_comb begin
        if (rst_n === 1'b0) begin
            AST_RST_FLOAT: assert (!data_oe && !eob_oe); // R1
        end
        if (out_en === 1'b0) begin
            AST_OE_FLOAT: assert (!data_oe && !eob_oe); // R6
        end
    end

endmodule

// File: tb/sim_burst_read_port.sv
`timescale 1ns/1ps
module sim_burst_read_port;

    logic        clk = 1'b0;
    logic        rst_n, chip_en, addr_vld, out_en, cfg_we;
    logic [15:0] addr_in;
    logic [5:0]  cfg_wdata;
    logic [31:0] data_out;
    logic        data_oe, eob_n, eob_oe;
    logic [15:0] arr_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    typedef struct {
        bit          chk_addr;
        logic [15:0] addr;
        bit          exp_doe;
        logic [31:0] dat;
        bit          oe_req;
        bit          eob_n;
        bit          first;
        bit          rs;
    } exp_t;

    exp_t q[$];
    exp_t it;

    always #2 clk = ~clk;

    burst_read_port u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_vld(addr_vld),
        .out_en(out_en), .addr_in(addr_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .data_out(data_out), .data_oe(data_oe), .eob_n(eob_n), .eob_oe(eob_oe),
        .arr_addr(arr_addr)
    );

    function automatic logic [31:0] word_of(input logic [15:0] a);
        return ({16'h0000, a} * 32'h0001_0001) ^ 32'hC3A5_0F1E;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic cfg_write(input bit early, input bit len8, input logic [2:0] lat);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {early, len8, lat, 1'b1};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Driver: pushes the expected cycle-by-cycle picture, then plays out_en
    task automatic run_burst(input logic [15:0] a, input int lat, input bit len8,
                             input bit early, input int float_beat, input int keep,
                             input bit rs);
        int   n     = len8 ? 8 : 4;
        int   total = lat - 1 + n + 1;
        bit   oe_arr[16];
        exp_t e;
        if (keep > 0 && keep < total) total = keep;
        @(negedge clk);
        for (int k = 0; k < total; k++) begin
            e.first = 1'b0;
            e.rs    = rs;
            if (k < lat - 1) begin
                e.chk_addr = 1'b1; e.addr = a; e.exp_doe = 1'b0; e.dat = '0;
                e.oe_req = 1'b1; e.eob_n = 1'b1;
            end else if (k < lat - 1 + n) begin
                int b = k - (lat - 1);
                e.chk_addr = 1'b1;
                e.addr     = a + 16'(b);
                e.dat      = word_of(a + 16'(b));
                e.oe_req   = (b != float_beat);
                e.exp_doe  = e.oe_req;
                e.eob_n    = (b != (early ? n - 2 : n - 1));
                e.first    = (b == 0);
            end else begin
                e.chk_addr = 1'b1; e.addr = a + 16'(n - 1); e.exp_doe = 1'b0;
                e.dat = '0; e.oe_req = 1'b1; e.eob_n = 1'b1;
            end
            oe_arr[k] = e.oe_req;
            q.push_back(e);
        end
        addr_in  = a;
        addr_vld = 1'b1;
        out_en   = oe_arr[0];
        for (int k = 1; k < total; k++) begin
            @(negedge clk);
            addr_vld = 1'b0;
            out_en   = oe_arr[k];
        end
        @(negedge clk);
        addr_vld = 1'b0;
        out_en   = 1'b1;
    endtask

    // Monitor: pops one expectation per cycle, 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                string ta;
                it = q.pop_front();
                ta = it.rs ? "R8" : (it.first ? "R3" : "R4");
                if (it.chk_addr)
                    chk(arr_addr == it.addr, it.oe_req ? ta : "R6", "arr_addr",
                        32'(arr_addr), 32'(it.addr));
                chk(data_oe == it.exp_doe, !it.oe_req ? "R6" : (it.exp_doe ? ta : "R3"),
                    "data_oe", 32'(data_oe), 32'(it.exp_doe));
                if (it.exp_doe)
                    chk(data_out == it.dat, ta, "data_out", data_out, it.dat);
                chk(eob_oe == it.oe_req, "R6", "eob_oe", 32'(eob_oe), 32'(it.oe_req));
                if (it.oe_req)
                    chk(eob_n == it.eob_n, "R5", "eob_n", 32'(eob_n), 32'(it.eob_n));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0; chip_en = 1'b1; addr_vld = 1'b0; out_en = 1'b1;
        cfg_we = 1'b0; cfg_wdata = '0; addr_in = 16'h0042;
        #1;
        chk(data_oe == 1'b0, "R1", "data_oe in reset", 32'(data_oe), 0);
        chk(eob_oe == 1'b0, "R1", "eob_oe in reset", 32'(eob_oe), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2: asynchronous default, combinational reads
        chk(data_oe == 1'b1, "R2", "async data_oe", 32'(data_oe), 1);
        chk(data_out == word_of(16'h0042), "R2", "async data", data_out, word_of(16'h0042));
        chk(eob_n == 1'b1, "R2", "async eob_n", 32'(eob_n), 1);
        addr_in = 16'h1357;
        #0.5;
        chk(data_out == word_of(16'h1357), "R2", "async data follow", data_out, word_of(16'h1357));
        @(negedge clk);
        addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0;
        addr_in  = 16'h2468;
        @(posedge clk);
        #1;
        chk(arr_addr == 16'h2468, "R2", "async ignores clock", 32'(arr_addr), 32'h2468);
        chk(data_oe == 1'b1, "R2", "async data_oe stays", 32'(data_oe), 1);

        // R3 R4 R5: latency 3, 4 beats, flag on last
        cfg_write(1'b0, 1'b0, 3'd3);
        run_burst(16'h0100, 3, 1'b0, 1'b0, -1, 0, 1'b0);
        // R4 no wrap across 0x00FF, R5 early flag, latency 5, 8 beats
        cfg_write(1'b1, 1'b1, 3'd5);
        run_burst(16'h00FD, 5, 1'b1, 1'b1, -1, 0, 1'b0);
        // R3 latency field 1 acts as 2
        cfg_write(1'b0, 1'b0, 3'd1);
        run_burst(16'h0200, 2, 1'b0, 1'b0, -1, 0, 1'b0);
        // R3 maximum latency 7
        cfg_write(1'b1, 1'b0, 3'd7);
        run_burst(16'h0280, 7, 1'b0, 1'b1, -1, 0, 1'b0);
        // R6 output enable dropped on a middle beat and on the flagged beat
        cfg_write(1'b0, 1'b1, 3'd3);
        run_burst(16'h0300, 3, 1'b1, 1'b0, 2, 0, 1'b0);
        run_burst(16'h0310, 3, 1'b1, 1'b0, 7, 0, 1'b0);
        // R8 restart mid-burst, then restart during the wait
        run_burst(16'h0400, 3, 1'b1, 1'b0, -1, 5, 1'b0);
        run_burst(16'h0500, 3, 1'b1, 1'b0, -1, 1, 1'b1);
        run_burst(16'h0600, 3, 1'b1, 1'b0, -1, 0, 1'b1);

        // R7 chip enable drop during a burst
        @(negedge clk);
        addr_in = 16'h0700; addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0;
        repeat (4) @(negedge clk);
        chip_en = 1'b0;
        #1;
        chk(data_oe == 1'b0, "R7", "data_oe chip off", 32'(data_oe), 0);
        @(posedge clk);
        #1;
        chk(arr_addr == 16'h0000, "R7", "arr_addr cleared", 32'(arr_addr), 0);
        @(negedge clk);
        chip_en = 1'b1;
        @(posedge clk);
        #1;
        chk(data_oe == 1'b0, "R7", "no resume", 32'(data_oe), 0);
        chk(arr_addr == 16'h0000, "R7", "addr stays clear", 32'(arr_addr), 0);

        // R1 reset in the middle of a burst
        @(negedge clk);
        addr_in = 16'h0800; addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(data_oe == 1'b1, "R1", "beat before reset", 32'(data_oe), 1);
        rst_n = 1'b0;
        #1;
        chk(data_oe == 1'b0, "R1", "data_oe reset mid-burst", 32'(data_oe), 0);
        chk(eob_oe == 1'b0, "R1", "eob_oe reset mid-burst", 32'(eob_oe), 0);
        @(negedge clk);
        rst_n   = 1'b1;
        addr_in = 16'h0ABC;
        #1;
        chk(data_oe == 1'b1, "R1", "default async after reset", 32'(data_oe), 1);
        chk(data_out == word_of(16'h0ABC), "R1", "async data after reset",
            data_out, word_of(16'h0ABC));
        chk(eob_n == 1'b1, "R1", "eob_n after reset", 32'(eob_n), 1);

        repeat (2) @(negedge clk);
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        report();
    end

endmodule